// File: doc/BRIEF.md
# Two-Level Interrupt Flag Controller

This block collects the interrupt events of a small processor core and turns them into a single registered interrupt request. Three core sources feed it: a one-cycle timer overflow pulse, an asynchronous external pin that is sensed on a selectable edge, and a group of asynchronous port pins that are watched for any change against a snapshot taken at the last port read. A vector of peripheral event pulses feeds it as well. Each event sets a sticky flag. Each flag has its own enable.

The request is gated at two levels. A global enable qualifies everything. A peripheral group enable further qualifies the peripheral flags only. Software owns a configuration word, a peripheral enable vector and per-flag clear strobes. Port reads are signalled by a strobe that reloads the change snapshot. A change flag that is cleared while the pins still differ from the snapshot comes straight back.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset all flags are 0, the interrupt request is 0, and the configuration word reads 6'b100000: only the edge-select bit is 1.
- R2: The configuration word is laid out as follows: bit 0 timer enable, bit 1 external enable, bit 2 change enable, bit 3 peripheral group enable, bit 4 global enable, bit 5 edge select. A timer pulse sets core flag bit 0 one clock after it is sampled, whatever the enables hold.
- R3: The external pin passes through two synchroniser flops. Its flag is core flag bit 1, and it is visible three clocks after the pin changes. It is set only on a rising pin edge when edge select is 1, and only on a falling edge when edge select is 0. The opposite edge has no effect.
- R4: Each port pin also passes through two synchroniser flops. When any synchronised port pin differs from the snapshot, core flag bit 2 is set. It becomes visible three clocks after the pin changes.
- R5: While the mismatch persists, the change flag is set again on every clock, so a clear has no lasting effect. A port read strobe reloads the snapshot from the synchronised pins. A clear that comes after the read takes effect.
- R6: A flag stays set until software clears it. A clear strobe on a bit takes that flag to 0 on the next clock.
- R7: When a hardware set and a software clear of the same flag fall on the same clock, the flag ends up set.
- R8: The request is registered. It is computed from the flags, the enables and the configuration one clock earlier. It is 1 when the global enable is 1 and either an enabled core flag is set, or the group enable is 1 and an enabled peripheral flag is set.
- R9: The peripheral group enable gates the peripheral flags only. Enabled core flags still raise the request while it is 0.
- R10: While the global enable is 0, the request is 0, even when enabled flags are set.
- R11: A peripheral event pulse sets its peripheral flag one clock after it is sampled, whatever the enables hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_ovf_i | input | 1 | Timer overflow pulse (synchronous) |
| ext_pin_i | input | 1 | External interrupt pin (asynchronous) |
| port_pins_i | input | PORT_W | Watched port pins (asynchronous) |
| port_rd_i | input | 1 | Port read strobe; reloads the change snapshot |
| periph_set_i | input | N_PERIPH | Peripheral event pulses |
| cfg_wr_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 6 | Configuration word write data |
| pen_wr_i | input | 1 | Peripheral enable vector write strobe |
| pen_wdata_i | input | N_PERIPH | Peripheral enable write data |
| core_clr_i | input | 3 | Core flag clear strobes (bit 0 timer, 1 external, 2 change) |
| periph_clr_i | input | N_PERIPH | Peripheral flag clear strobes |
| core_flags_o | output | 3 | Core flags |
| periph_flags_o | output | N_PERIPH | Peripheral flags |
| cfg_o | output | 6 | Current configuration word |
| pen_o | output | N_PERIPH | Current peripheral enable vector |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A synchronous pulse, a register write or a clear strobe shows up on the flag and configuration outputs one clock after it is sampled. A pin change takes three clocks, counting the two synchroniser flops and the flag register. The request trails its inputs by one further clock. Stimulus is applied on the falling edge and results are read on a later falling edge, so each check counts the exact number of rising edges since its stimulus. Pin tests read the flag both one clock before and at the due clock, which pins the latency down from both sides. The flag-clear corner cases are covered: a clear during a persisting mismatch, a clear on the same clock as a read, and a clear on the same clock as a set.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CORE_W = 3;
  localparam int CORE_TMR = 0;
  localparam int CORE_EXT = 1;
  localparam int CORE_CHG = 2;

  typedef struct packed {
    logic edge_rise;
    logic glb_en;
    logic grp_en;
    logic chg_en;
    logic ext_en;
    logic tmr_en;
  } irq_cfg_t;

  localparam int CFG_W = $bits(irq_cfg_t);
  localparam irq_cfg_t CFG_RESET = '{edge_rise: 1'b1, default: 1'b0};
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_i[i];
        stab_q <= meta_q;
      end
    end
    assign q_o[i] = stab_q;
  end
endmodule

// File: rtl/irq_pin_events.sv
module irq_pin_events #(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_s_i,
  input  logic [PORT_W-1:0] port_s_i,
  input  logic              edge_rise_i,
  input  logic              port_rd_i,
  output logic              ext_evt_o,
  output logic              chg_evt_o
);
  logic              ext_prev_q;
  logic [PORT_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_prev_q <= 1'b0;
      snap_q     <= '0;
    end else begin
      ext_prev_q <= ext_s_i;
      if (port_rd_i) snap_q <= port_s_i;
    end
  end

  always_comb begin
    if (edge_rise_i) ext_evt_o = ext_s_i & ~ext_prev_q;
    else             ext_evt_o = ~ext_s_i & ext_prev_q;
  end

  assign chg_evt_o = |(port_s_i ^ snap_q);

  AST_EDGE_POLARITY: assert property (@(posedge clk) disable iff (rst)
    ext_evt_o |-> (ext_s_i == edge_rise_i && ext_prev_q != ext_s_i)); // R3
  AST_SNAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    port_rd_i |=> !chg_evt_o || ($past(port_s_i) != port_s_i)); // R5
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= (flags_o & ~clr_i) | set_i;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i))); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|flags_o) |=> (($past(flags_o) & ~$past(clr_i) & ~flags_o) == '0)); // R6
  AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~set_i)) |=> ((flags_o & $past(clr_i & ~set_i)) == '0)); // R6
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(set_i)) == '0)); // R2
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int PORT_W   = 4,
  parameter int N_PERIPH = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tmr_ovf_i,
  input  logic                ext_pin_i,
  input  logic [PORT_W-1:0]   port_pins_i,
  input  logic                port_rd_i,
  input  logic [N_PERIPH-1:0] periph_set_i,
  input  logic                cfg_wr_i,
  input  logic [5:0]          cfg_wdata_i,
  input  logic                pen_wr_i,
  input  logic [N_PERIPH-1:0] pen_wdata_i,
  input  logic [2:0]          core_clr_i,
  input  logic [N_PERIPH-1:0] periph_clr_i,
  output logic [2:0]          core_flags_o,
  output logic [N_PERIPH-1:0] periph_flags_o,
  output logic [5:0]          cfg_o,
  output logic [N_PERIPH-1:0] pen_o,
  output logic                irq_o
);
  localparam int SYNC_W = PORT_W + 1;

  irq_cfg_t            cfg_q;
  logic [N_PERIPH-1:0] pen_q;
  logic [SYNC_W-1:0]   pins_s;
  logic                ext_evt, chg_evt;
  logic [CORE_W-1:0]   core_set, core_en;
  logic                core_hit, periph_hit;

  irq_sync #(.W(SYNC_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({port_pins_i, ext_pin_i}),
    .q_o (pins_s)
  );

  irq_pin_events #(.PORT_W(PORT_W)) u_events (
    .clk         (clk),
    .rst         (rst),
    .ext_s_i     (pins_s[0]),
    .port_s_i    (pins_s[SYNC_W-1:1]),
    .edge_rise_i (cfg_q.edge_rise),
    .port_rd_i   (port_rd_i),
    .ext_evt_o   (ext_evt),
    .chg_evt_o   (chg_evt)
  );

  always_comb begin
    core_set           = '0;
    core_set[CORE_TMR] = tmr_ovf_i;
    core_set[CORE_EXT] = ext_evt;
    core_set[CORE_CHG] = chg_evt;
    core_en            = '0;
    core_en[CORE_TMR]  = cfg_q.tmr_en;
    core_en[CORE_EXT]  = cfg_q.ext_en;
    core_en[CORE_CHG]  = cfg_q.chg_en;
  end

  irq_flag_bank #(.W(CORE_W)) u_core_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (core_set),
    .clr_i   (core_clr_i),
    .flags_o (core_flags_o)
  );

  irq_flag_bank #(.W(N_PERIPH)) u_periph_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (periph_set_i),
    .clr_i   (periph_clr_i),
    .flags_o (periph_flags_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
      pen_q <= '0;
    end else begin
      if (cfg_wr_i) cfg_q <= irq_cfg_t'(cfg_wdata_i);
      if (pen_wr_i) pen_q <= pen_wdata_i;
    end
  end

  assign core_hit   = |(core_flags_o & core_en);
  assign periph_hit = cfg_q.grp_en & (|(periph_flags_o & pen_q));

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= cfg_q.glb_en & (core_hit | periph_hit);
  end

  assign cfg_o = cfg_q;
  assign pen_o = pen_q;

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.glb_en |=> !irq_o); // R10
  AST_GROUP_GATE: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.grp_en && !core_hit) |=> !irq_o); // R9
  AST_CORE_RAISES: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.glb_en && core_hit) |=> irq_o); // R8
  AST_CHG_PERSISTS: assert property (@(posedge clk) disable iff (rst)
    (chg_evt && !port_rd_i) |=> core_flags_o[CORE_CHG]); // R5
endmodule

// File: tb/sim_irq_flag_ctrl.sv
`timescale 1ns/1ps
module sim_irq_flag_ctrl;
  localparam int PW = 4;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tmr = 1'b0, ext = 1'b0, prd = 1'b0;
  logic [PW-1:0] pins = '0;
  logic [NP-1:0] pset = '0, pclr = '0, pen_d = '0;
  logic          cfg_wr = 1'b0, pen_wr = 1'b0;
  logic [5:0]    cfg_d = '0;
  logic [2:0]    cclr = '0;
  logic [2:0]    cflags;
  logic [NP-1:0] pflags, pen;
  logic [5:0]    cfg;
  logic          irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_flag_ctrl #(.PORT_W(PW), .N_PERIPH(NP)) u0 (
    .clk(clk), .rst(rst), .tmr_ovf_i(tmr), .ext_pin_i(ext), .port_pins_i(pins),
    .port_rd_i(prd), .periph_set_i(pset), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_d),
    .pen_wr_i(pen_wr), .pen_wdata_i(pen_d), .core_clr_i(cclr), .periph_clr_i(pclr),
    .core_flags_o(cflags), .periph_flags_o(pflags), .cfg_o(cfg), .pen_o(pen), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [5:0] v);
    cfg_d = v; cfg_wr = 1'b1; step(1); cfg_wr = 1'b0;
  endtask

  task automatic clr_core(input logic [2:0] m);
    cclr = m; step(1); cclr = '0;
  endtask

  task automatic t_reset;
    chk("R1 core flags", cflags, 0);
    chk("R1 periph flags", pflags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 cfg", cfg, 6'b100000);
  endtask

  task automatic t_timer;
    tmr = 1'b1; step(1); tmr = 1'b0;
    chk("R2 timer flag set without enables", cflags, 3'b001);
    step(5);
    chk("R6 flag sticky", cflags, 3'b001);
    chk("R10 no irq with global off", irq, 0);
    clr_core(3'b001);
    chk("R6 clear", cflags, 0);
    tmr = 1'b1; cclr = 3'b001; step(1); tmr = 1'b0; cclr = '0;
    chk("R7 set beats clear", cflags, 3'b001);
    clr_core(3'b001);
  endtask

  task automatic t_ext;
    ext = 1'b1; step(2);
    chk("R3 ext not yet due", cflags[1], 0);
    step(1);
    chk("R3 rising edge sets", cflags[1], 1);
    clr_core(3'b010);
    ext = 1'b0; step(4);
    chk("R3 falling ignored in rise mode", cflags[1], 0);
    write_cfg(6'b000000);
    ext = 1'b1; step(4);
    chk("R3 rising ignored in fall mode", cflags[1], 0);
    ext = 1'b0; step(3);
    chk("R3 falling edge sets", cflags[1], 1);
    clr_core(3'b010);
    write_cfg(6'b100000);
  endtask

  task automatic t_port;
    pins = 4'b0100; step(2);
    chk("R4 change not yet due", cflags[2], 0);
    step(1);
    chk("R4 change sets", cflags[2], 1);
    clr_core(3'b100);
    chk("R5 clear during mismatch", cflags[2], 1);
    prd = 1'b1; cclr = 3'b100; step(1); prd = 1'b0; cclr = '0;
    chk("R5 clear with read same clock", cflags[2], 1);
    clr_core(3'b100);
    chk("R5 clear after read", cflags[2], 0);
    step(3);
    chk("R5 stays clear after resync", cflags[2], 0);
    pins = 4'b0000; step(3);
    chk("R4 change back sets", cflags[2], 1);
    prd = 1'b1; step(1); prd = 1'b0;
    clr_core(3'b100);
    chk("R5 cleared", cflags[2], 0);
  endtask

  task automatic t_irq_core;
    write_cfg(6'b110001);
    tmr = 1'b1; step(1); tmr = 1'b0;
    chk("R8 irq lags flag", irq, 0);
    step(1);
    chk("R8 irq raised", irq, 1);
    write_cfg(6'b100001); step(1);
    chk("R10 global off drops irq", irq, 0);
    write_cfg(6'b110001); step(1);
    chk("R9 core irq without group enable", irq, 1);
    clr_core(3'b001);
    chk("R6 cleared flag", cflags, 0);
    step(1);
    chk("R8 irq drops after clear", irq, 0);
  endtask

  task automatic t_periph;
    write_cfg(6'b110000);
    pset = 8'h02; step(1); pset = '0;
    chk("R11 periph flag set", pflags, 8'h02);
    pen_d = 8'h02; pen_wr = 1'b1; step(1); pen_wr = 1'b0;
    step(1);
    chk("R9 group enable off blocks periph", irq, 0);
    write_cfg(6'b111000); step(1);
    chk("R9 group enable passes periph", irq, 1);
    pen_d = 8'h00; pen_wr = 1'b1; step(1); pen_wr = 1'b0; step(1);
    chk("R8 per-source enable masks", irq, 0);
    pclr = 8'h02; step(1); pclr = '0;
    chk("R6 periph clear", pflags, 0);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_timer();
    t_ext();
    t_port();
    t_irq_core();
    t_periph();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule